// File: doc/BRIEF.md
# Interrupt Pending Priority Selector

This block sits inside a hart next to the trap logic. Each cycle it looks at which interrupts are both raised and enabled, applies the gating that the current privilege level and the delegation mask impose, and names the one interrupt that should be taken next. Of all the candidates that survive gating, the one with the lowest index wins. The result is registered, so the trap logic sees a valid strobe, a cause index and a flag one clock after the inputs it was computed from.

When the hart runs a virtual guest, the three virtual-supervisor interrupt lines (software, timer, external) are set apart from the rest. Any other surviving candidate belongs to the hypervisor level. It is gated by the hypervisor's own supervisor enable and takes precedence over the guest lines. When such a candidate wins, the selector raises a flag telling trap entry to route the trap to the hypervisor level. Only when no such candidate is left do the guest lines go through the ordinary delegation gating.

Top module: `irq_select`

## Requirements
- R1: The candidate set is the bitwise AND of `pendVec` and `enableVec`. A bit whose enable is clear is never reported, even when it is pending.
- R2: The machine gate is open when `privLvl` (encoded user=0, supervisor=1, machine=3) is below 3, or when it is 3 and `mieGlobal` is 1. A candidate whose `delegMask` bit is 0 is reported only when this gate is open.
- R3: The supervisor gate is open when `privLvl` is 0, or when it is 1 and `sieGlobal` is 1. A candidate whose `delegMask` bit is 1 is reported only when this gate is open.
- R4: Delegated and non-delegated candidates are gated separately and then merged, so that at machine level with `mieGlobal`=1 a delegated candidate is dropped while a non-delegated one is still taken.
- R5: Among the candidates that survive gating, the one with the lowest index is reported in `irqCause`.
- R6: When no candidate survives, `irqValid` is 0.
- R7: With `virtOn`=1, candidates other than bits 2, 6 and 10 are gated by a hypervisor gate. This gate is open when `privLvl` is 0, or when it is 1 and `hsSieGlobal` is 1. If any of these candidates survive, the lowest one is reported with `forceHyp`=1, ahead of every guest line.
- R8: With `virtOn`=1 and no surviving hypervisor-level candidate, only bits 2, 6 and 10 of the candidate set go through the R2/R3 delegation gating, and `forceHyp` is 0.
- R9: With `virtOn`=0, bits 2, 6 and 10 are treated like any other bit, `hsSieGlobal` has no effect, and `forceHyp` is 0.
- R10: Outputs change exactly one rising edge after the inputs. `irqValid` and `irqCause` update on the same edge, and `irqCause` is 0 whenever `irqValid` is 0.
- R11: A synchronous active-high `rst` clears `irqValid`, `forceHyp` and `irqCause` at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pendVec | input | 32 | Pending interrupt lines |
| enableVec | input | 32 | Per-line interrupt enables |
| delegMask | input | 32 | 1 = line delegated to supervisor level |
| privLvl | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| mieGlobal | input | 1 | Global machine interrupt enable |
| sieGlobal | input | 1 | Global supervisor interrupt enable (current context) |
| hsSieGlobal | input | 1 | Hypervisor-level supervisor interrupt enable |
| virtOn | input | 1 | Hart is executing a virtual guest |
| irqValid | output | 1 | An interrupt should be taken |
| irqCause | output | 5 | Index of the selected interrupt |
| forceHyp | output | 1 | Selected interrupt must trap to hypervisor level |

## Verification
All three outputs are due exactly one rising edge after the inputs they depend on. The bench therefore drives each stimulus on a falling edge and compares at the following falling edge, so one rising edge has passed in between. One directed check samples just before that rising edge to confirm that the previous result is still held, and that nothing leaks through combinationally. A sweep over every privilege code and every enable and virtualization bit, crossed with computed vector patterns, is compared against an arithmetic model of the gating and the lowest-index rule.

// File: rtl/irq_select_pkg.sv
package irq_select_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  // Strobes handed from the control decode to the datapath
  typedef struct packed {
    logic machOpen;
    logic supOpen;
    logic hypSupOpen;
    logic virtMode;
  } gate_t;

endpackage

// File: rtl/irq_select_ctrl.sv
module irq_select_ctrl
  import irq_select_pkg::*;
(
  input  logic [1:0] privLvl,
  input  logic       mieGlobal,
  input  logic       sieGlobal,
  input  logic       hsSieGlobal,
  input  logic       virtOn,
  output gate_t      gate
);

  priv_e curPriv;
  logic  belowMach;
  logic  belowSuper;
  logic  atMach;
  logic  atSuper;

  always_comb begin
    curPriv    = priv_e'(privLvl);
    belowMach  = (curPriv != PRIV_MACH);
    atMach     = (curPriv == PRIV_MACH);
    belowSuper = (curPriv == PRIV_USER);
    atSuper    = (curPriv == PRIV_SUPER);

    gate.machOpen   = belowMach  || (atMach  && mieGlobal);
    gate.supOpen    = belowSuper || (atSuper && sieGlobal);
    gate.hypSupOpen = belowSuper || (atSuper && hsSieGlobal);
    gate.virtMode   = virtOn;
  end

endmodule

// File: rtl/irq_select_dp.sv
module irq_select_dp
  import irq_select_pkg::*;
#(
  parameter int VEC_W   = 32,
  parameter int CAUSE_W = $clog2(VEC_W),
  parameter int VS_SW   = 2,
  parameter int VS_TM   = 6,
  parameter int VS_EX   = 10
) (
  input  gate_t              gate,
  input  logic [VEC_W-1:0]   pendVec,
  input  logic [VEC_W-1:0]   enableVec,
  input  logic [VEC_W-1:0]   delegMask,
  output logic               nxtValid,
  output logic [CAUSE_W-1:0] nxtCause,
  output logic               nxtForce
);

  logic [VEC_W-1:0] guestMask;
  logic [VEC_W-1:0] candVec;
  logic [VEC_W-1:0] hypCand;
  logic [VEC_W-1:0] routeVec;
  logic [VEC_W-1:0] normVec;
  logic [VEC_W-1:0] pickVec;
  logic             hypHit;

  for (genvar i = 0; i < VEC_W; i++) begin : g_guest
    assign guestMask[i] = (i == VS_SW) || (i == VS_TM) || (i == VS_EX);
  end

  always_comb begin
    candVec  = pendVec & enableVec;
    hypCand  = candVec & ~guestMask & {VEC_W{gate.hypSupOpen}};
    hypHit   = gate.virtMode && (|hypCand);
    routeVec = gate.virtMode ? (candVec & guestMask) : candVec;
    normVec  = (routeVec & ~delegMask & {VEC_W{gate.machOpen}}) |
               (routeVec &  delegMask & {VEC_W{gate.supOpen}});
    pickVec  = hypHit ? hypCand : normVec;
  end

  // Lowest set index wins: scan from the top so the last hit is the lowest
  always_comb begin
    nxtCause = '0;
    for (int i = VEC_W - 1; i >= 0; i--) begin
      if (pickVec[i]) nxtCause = CAUSE_W'(i);
    end
    nxtValid = |pickVec;
    nxtForce = hypHit;
  end

endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_select_pkg::*;
#(
  parameter int VEC_W   = 32,
  parameter int CAUSE_W = $clog2(VEC_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [VEC_W-1:0]   pendVec,
  input  logic [VEC_W-1:0]   enableVec,
  input  logic [VEC_W-1:0]   delegMask,
  input  logic [1:0]         privLvl,
  input  logic               mieGlobal,
  input  logic               sieGlobal,
  input  logic               hsSieGlobal,
  input  logic               virtOn,
  output logic               irqValid,
  output logic [CAUSE_W-1:0] irqCause,
  output logic               forceHyp
);

  gate_t              gate;
  logic               nxtValid;
  logic [CAUSE_W-1:0] nxtCause;
  logic               nxtForce;

  irq_select_ctrl u_ctrl (
    .privLvl    (privLvl),
    .mieGlobal  (mieGlobal),
    .sieGlobal  (sieGlobal),
    .hsSieGlobal(hsSieGlobal),
    .virtOn     (virtOn),
    .gate       (gate)
  );

  irq_select_dp #(.VEC_W(VEC_W), .CAUSE_W(CAUSE_W)) u_dp (
    .gate     (gate),
    .pendVec  (pendVec),
    .enableVec(enableVec),
    .delegMask(delegMask),
    .nxtValid (nxtValid),
    .nxtCause (nxtCause),
    .nxtForce (nxtForce)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irqValid <= 1'b0;
      irqCause <= '0;
      forceHyp <= 1'b0;
    end else begin
      irqValid <= nxtValid;
      irqCause <= nxtCause;
      forceHyp <= nxtForce;
    end
  end

endmodule

// File: rtl/irq_select_chk.sv
module irq_select_chk #(
  parameter int VEC_W   = 32,
  parameter int CAUSE_W = $clog2(VEC_W)
) (
  input logic               clk,
  input logic               rst,
  input logic [VEC_W-1:0]   pendVec,
  input logic [VEC_W-1:0]   enableVec,
  input logic [1:0]         privLvl,
  input logic               mieGlobal,
  input logic               virtOn,
  input logic               irqValid,
  input logic [CAUSE_W-1:0] irqCause,
  input logic               forceHyp
);

  logic [VEC_W-1:0] candQ;
  logic             virtQ;

  always_ff @(posedge clk) begin
    candQ <= pendVec & enableVec;
    virtQ <= virtOn;
  end

  AST_CAUSE_IS_CANDIDATE: assert property (@(posedge clk) disable iff (rst)
    irqValid |-> candQ[irqCause]); // R1
  AST_MACH_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (privLvl == 2'd3 && !mieGlobal && !virtOn) |=> !irqValid); // R2
  AST_EMPTY_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    ((pendVec & enableVec) == '0) |=> !irqValid); // R6
  AST_FORCE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    forceHyp |-> irqValid); // R7
  AST_FORCE_NEEDS_VIRT: assert property (@(posedge clk) disable iff (rst)
    forceHyp |-> virtQ); // R9
  AST_IDLE_CAUSE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !irqValid |-> (irqCause == '0)); // R10
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!irqValid && !forceHyp)); // R11

endmodule

bind irq_select irq_select_chk #(.VEC_W(VEC_W), .CAUSE_W(CAUSE_W)) u_chk (.*);

// File: tb/sim_irq_select.sv
module sim_irq_select;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] pendVec, enableVec, delegMask;
  logic [1:0]  privLvl;
  logic        mieGlobal, sieGlobal, hsSieGlobal, virtOn;
  logic        irqValid;
  logic [4:0]  irqCause;
  logic        forceHyp;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  irq_select u0 (
    .clk(clk), .rst(rst), .pendVec(pendVec), .enableVec(enableVec),
    .delegMask(delegMask), .privLvl(privLvl), .mieGlobal(mieGlobal),
    .sieGlobal(sieGlobal), .hsSieGlobal(hsSieGlobal), .virtOn(virtOn),
    .irqValid(irqValid), .irqCause(irqCause), .forceHyp(forceHyp)
  );

  // Model: returns {valid, cause[4:0], force}
  function automatic logic [6:0] model();
    logic [31:0] cand, guest, hyp, route, norm, pick;
    logic mOpen, sOpen, hOpen, hit;
    logic [4:0] c;
    guest = 32'h0000_0444;
    mOpen = (privLvl != 2'd3) || mieGlobal;
    sOpen = (privLvl == 2'd0) || (privLvl == 2'd1 && sieGlobal);
    hOpen = (privLvl == 2'd0) || (privLvl == 2'd1 && hsSieGlobal);
    cand  = pendVec & enableVec;
    hyp   = hOpen ? (cand & ~guest) : 32'h0;
    hit   = virtOn && (hyp != 0);
    route = virtOn ? (cand & guest) : cand;
    norm  = (mOpen ? (route & ~delegMask) : 32'h0) |
            (sOpen ? (route & delegMask) : 32'h0);
    pick  = hit ? hyp : norm;
    c = 5'd0;
    for (int i = 31; i >= 0; i--) if (pick[i]) c = 5'(i);
    return {(pick != 0), c, hit};
  endfunction

  task automatic check(input string tag, input logic [6:0] exp);
    total++;
    if ({irqValid, irqCause, forceHyp} !== exp) begin
      bad++;
      $display("FAIL %s: got valid=%0b cause=%0d force=%0b exp valid=%0b cause=%0d force=%0b",
               tag, irqValid, irqCause, forceHyp, exp[6], exp[5:1], exp[0]);
    end
  endtask

  task automatic setCtl(input logic [1:0] p, input logic m, input logic s,
                        input logic h, input logic v);
    privLvl = p; mieGlobal = m; sieGlobal = s; hsSieGlobal = h; virtOn = v;
  endtask

  task automatic setVec(input logic [31:0] pv, input logic [31:0] ev, input logic [31:0] dm);
    pendVec = pv; enableVec = ev; delegMask = dm;
  endtask

  // one rising edge, then sample at the next falling edge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic done();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog: got hung expected finish");
    done();
  end

  initial begin
    rst = 1'b1;
    setCtl(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    setVec(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0);
    @(negedge clk); step();
    check("R11 reset state", 7'b0_00000_0);
    rst = 1'b0;

    // R1: pending but not enabled
    setVec(32'hFFFF_FFFF, 32'h0, 32'h0); step();
    check("R1 enable clear", 7'b0_00000_0);
    // R6: nothing pending
    setVec(32'h0, 32'hFFFF_FFFF, 32'h0); step();
    check("R6 none pending", 7'b0_00000_0);
    // R2: machine gate
    setCtl(2'd3, 1'b0, 1'b1, 1'b1, 1'b0);
    setVec(32'h80, 32'h80, 32'h0); step();
    check("R2 machine closed", 7'b0_00000_0);
    mieGlobal = 1'b1; step();
    check("R2 machine open", {1'b1, 5'd7, 1'b0});
    // R3: supervisor gate
    setCtl(2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    setVec(32'h20, 32'h20, 32'h20); step();
    check("R3 super closed", 7'b0_00000_0);
    sieGlobal = 1'b1; step();
    check("R3 super open", {1'b1, 5'd5, 1'b0});
    setCtl(2'd0, 1'b0, 1'b0, 1'b0, 1'b0); step();
    check("R3 user below super", {1'b1, 5'd5, 1'b0});
    // R4: delegated dropped at machine
    setCtl(2'd3, 1'b1, 1'b1, 1'b0, 1'b0);
    setVec(32'h208, 32'h208, 32'h8); step();
    check("R4 delegation split", {1'b1, 5'd9, 1'b0});
    // R5: lowest wins
    setCtl(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    setVec(32'h4000_1010, 32'hFFFF_FFFF, 32'h0); step();
    check("R5 lowest index", {1'b1, 5'd4, 1'b0});
    // R7: hypervisor candidate wins over guest line
    setCtl(2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    setVec(32'h804, 32'hFFFF_FFFF, 32'h0); step();
    check("R7 hyp wins", {1'b1, 5'd11, 1'b1});
    // R8: guest lines only, via delegation
    setCtl(2'd1, 1'b0, 1'b1, 1'b0, 1'b1);
    setVec(32'h844, 32'hFFFF_FFFF, 32'h44); step();
    check("R8 guest via delegation", {1'b1, 5'd2, 1'b0});
    // R9: no virt, guest bit is ordinary, hsSie irrelevant
    setCtl(2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    setVec(32'h804, 32'hFFFF_FFFF, 32'h0); step();
    check("R9 no virt", {1'b1, 5'd2, 1'b0});
    // R10: output held until the rising edge
    setVec(32'h0, 32'h0, 32'h0);
    #1 check("R10 held before edge", {1'b1, 5'd2, 1'b0});
    step();
    check("R10 after one edge", 7'b0_00000_0);

    // Sweep of every control combination against computed patterns
    for (int k = 0; k < 12; k++) begin
      for (int c = 0; c < 64; c++) begin
        logic [6:0] exp;
        logic [31:0] pv, ev;
        pv = 32'h9E37_79B9 * (k + 1);
        ev = (32'h85EB_CA6B * (k + 3)) ^ (pv >> 3);
        if (k % 3 == 1) pv = pv & 32'h0000_0444 | (pv & 32'h0100_0000);
        if (k % 4 == 2) ev = 32'hFFFF_FFFF;
        setVec(pv, ev, 32'hC2B2_AE35 * (k + 7));
        setCtl(c[1:0], c[2], c[3], c[4], c[5]);
        exp = model();
        step();
        if (exp[0])        check("R7 sweep", exp);
        else if (virtOn)   check("R8 sweep", exp);
        else if (exp[6])   check("R5 sweep", exp);
        else               check("R6 sweep", exp);
      end
    end

    // R11: reset mid-run clears a pending result
    setCtl(2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    setVec(32'h800, 32'h800, 32'h0); step();
    check("R7 pre-reset", {1'b1, 5'd11, 1'b1});
    rst = 1'b1; step();
    check("R11 mid-run reset", 7'b0_00000_0);
    rst = 1'b0; step();
    check("R10 after reset release", {1'b1, 5'd11, 1'b1});

    done();
  end

endmodule